// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block decides, every cycle, how operands reach the ALU and the branch comparator of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It compares the source register numbers of younger instructions with the destination register numbers of older instructions still in flight. From that comparison it produces bypass selects for both ALU inputs, bypass enables for the two branch compare operands in decode, and a single interlock that freezes fetch and injects an empty slot into execute. It also produces a redirect pulse when a branch resolved in decode is taken.

Registers are read only in decode and written only in writeback, so only read-after-write dependences are tracked. The register file is assumed to complete its writeback write before its decode read in the same cycle, so decode never needs a bypass from the writeback stage. A thin stage-register shell carries the decoded register fields and the write and load flags from decode down to writeback, so the block can be driven with a plain instruction stream. Branches take effect after one architectural delay slot. The instruction in that slot is never squashed.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset every stage holds an empty instruction, and all outputs (`fwd_a_sel`, `fwd_b_sel`, `br_fwd_a`, `br_fwd_b`, `hold`, `bubble`, `redirect`) are zero.
- R2: An ALU operand select is 2'b10 when the instruction in the memory stage writes the register that the execute-stage instruction reads. It is 2'b01 when only the writeback-stage instruction writes it. Otherwise it is 2'b00, the register-file value. The value 2'b11 never appears.
- R3: When the memory-stage and writeback-stage instructions both write the register being read, the select is 2'b10, so the younger value wins.
- R4: A write to register 0 never produces a bypass select, a branch bypass, or an interlock. A read of register 0 always selects 2'b00.
- R5: A load in execute whose destination is read by the instruction in decode raises `hold` and `bubble` for exactly one cycle. The dependent instruction then takes the loaded value with select 2'b01.
- R6: Fields are decoded from the 6-bit opcode in bits 31:26. Opcode 0x00 (register form) reads bits 25:21 and 20:16 and writes bits 15:11. Opcodes 0x08 (add immediate) and 0x23 (load) read bits 25:21 and write bits 20:16. Opcode 0x2B (store) reads both source fields and writes nothing.
- R7: A branch (opcode 0x04, reading bits 25:21 and 20:16) in decode stalls while a source is written by the instruction in execute, or by a load in the memory stage. This costs one cycle after an ALU writer and two cycles after a load.
- R8: A branch in decode whose source is written by a non-load instruction in the memory stage raises that operand's branch bypass (`br_fwd_a` for bits 25:21, `br_fwd_b` for bits 20:16).
- R9: `redirect` is high exactly when a branch sits in decode, `br_cond` is high, and no interlock is active. `br_cond` has no effect for any other instruction. The next fetched instruction still enters decode as the delay slot.
- R10: While `hold` is high, the decode-stage instruction is kept and `bubble` is high. The execute stage then receives an instruction that reads and writes nothing, so that slot raises no bypass.
- R11: Any other opcode reads and writes no register, and never causes a bypass or an interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_instr | input | 32 | Instruction word fetched this cycle, captured into decode unless held |
| br_cond | input | 1 | Outcome of the decode-stage compare for the branch in decode |
| fwd_a_sel | output | 2 | Bypass select for the first ALU operand |
| fwd_b_sel | output | 2 | Bypass select for the second ALU operand |
| br_fwd_a | output | 1 | Take the first branch operand from the memory-stage result |
| br_fwd_b | output | 1 | Take the second branch operand from the memory-stage result |
| hold | output | 1 | Freeze the program counter and the decode register |
| bubble | output | 1 | Insert an empty instruction into execute |
| redirect | output | 1 | Taken branch resolved in decode; fetch the target after the delay slot |

## Verification
A stage register that drops or corrupts a destination field shows up within one to three cycles. A dependent instruction then gets 2'b00 where 2'b10 or 2'b01 is due, or a bypass appears for an unrelated register. A wrong load flag or a wrong interlock term shows at the ports in the same cycle. It appears as a missing or doubled `hold`, and as a dependent that reaches execute one cycle early or late, so its select pattern shifts. Because the bench compares every output against a behavioural pipeline model on every cycle, the first divergent cycle is reported directly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   localparam int unsigned INSTR_W = 32;
   localparam int unsigned OPC_W   = 6;
   localparam int unsigned REG_W   = 5;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned N_SRC   = 2;

   typedef logic [REG_W-1:0] regno_t;

   // decoded register usage carried down the pipe
   typedef struct packed {
      regno_t ra;
      regno_t rb;
      regno_t rd;
      logic   ra_rd;
      logic   rb_rd;
      logic   wr;
      logic   ld;
      logic   br;
   } uop_t;

   localparam logic [SEL_W-1:0] SEL_RF = 2'b00;
   localparam logic [SEL_W-1:0] SEL_WB = 2'b01;
   localparam logic [SEL_W-1:0] SEL_EM = 2'b10;

   // true when an older writer produces the register a reader needs
   function automatic logic reg_hit(input logic wr, input regno_t dst,
                                    input regno_t src, input logic used);
      return wr && used && (dst != '0) && (dst == src);
   endfunction
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
   import hzd_pkg::*;
#(
   parameter logic [OPC_W-1:0] OPC_REG    = 6'h00,
   parameter logic [OPC_W-1:0] OPC_ADDI   = 6'h08,
   parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04
) (
   input  logic [INSTR_W-1:0] instr,
   output uop_t               uop
);
   localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
   localparam int unsigned RA_LSB  = OPC_LSB - REG_W;
   localparam int unsigned RB_LSB  = RA_LSB - REG_W;
   localparam int unsigned RD_LSB  = RB_LSB - REG_W;

   if (RD_LSB < 1) begin : g_bad_layout
      $error("instruction word too narrow for three register fields");
   end
   if (OPC_REG == OPC_LOAD || OPC_LOAD == OPC_STORE || OPC_BRANCH == OPC_ADDI) begin : g_bad_opc
      $error("opcode parameters must be distinct");
   end

   logic [OPC_W-1:0] opc;
   regno_t           f_a, f_b, f_d;
   logic             unused_low;

   assign opc        = instr[INSTR_W-1:OPC_LSB];
   assign f_a        = instr[RA_LSB +: REG_W];
   assign f_b        = instr[RB_LSB +: REG_W];
   assign f_d        = instr[RD_LSB +: REG_W];
   assign unused_low = ^instr[RD_LSB-1:0];

   always_comb begin
      uop = '0;
      unique case (opc)
         OPC_REG: begin
            uop.ra = f_a;  uop.ra_rd = 1'b1;
            uop.rb = f_b;  uop.rb_rd = 1'b1;
            uop.rd = f_d;  uop.wr    = 1'b1;
         end
         OPC_ADDI: begin
            uop.ra = f_a;  uop.ra_rd = 1'b1;
            uop.rd = f_b;  uop.wr    = 1'b1;
         end
         OPC_LOAD: begin
            uop.ra = f_a;  uop.ra_rd = 1'b1;
            uop.rd = f_b;  uop.wr    = 1'b1;
            uop.ld = 1'b1;
         end
         OPC_STORE: begin
            uop.ra = f_a;  uop.ra_rd = 1'b1;
            uop.rb = f_b;  uop.rb_rd = 1'b1;
         end
         OPC_BRANCH: begin
            uop.ra = f_a;  uop.ra_rd = 1'b1;
            uop.rb = f_b;  uop.rb_rd = 1'b1;
            uop.br = 1'b1;
         end
         default: uop = '0;
      endcase
   end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
(
   input  regno_t           src,
   input  logic             used,
   input  logic             em_wr,
   input  regno_t           em_rd,
   input  logic             wb_wr,
   input  regno_t           wb_rd,
   output logic [SEL_W-1:0] sel
);
   logic em_hit, wb_hit;

   assign em_hit = reg_hit(em_wr, em_rd, src, used);
   assign wb_hit = reg_hit(wb_wr, wb_rd, src, used);

   // memory stage holds the younger result, so it is tested first
   always_comb begin
      if (em_hit)      sel = SEL_EM;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
   import hzd_pkg::*;
(
   input  regno_t [N_SRC-1:0] id_src,
   input  logic   [N_SRC-1:0] id_use,
   input  logic               id_br,
   input  logic               x_wr,
   input  regno_t             x_rd,
   input  logic               x_ld,
   input  logic               m_wr,
   input  regno_t             m_rd,
   input  logic               m_ld,
   input  logic               br_cond,
   output logic [N_SRC-1:0]   br_fwd,
   output logic               lu_stall,
   output logic               hold,
   output logic               bubble,
   output logic               redirect
);
   logic [N_SRC-1:0] lu_hit;
   logic [N_SRC-1:0] bx_hit;

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
      logic x_hit, m_hit;
      assign x_hit      = reg_hit(x_wr, x_rd, id_src[gi], id_use[gi]);
      assign m_hit      = reg_hit(m_wr, m_rd, id_src[gi], id_use[gi]);
      assign lu_hit[gi] = x_ld & x_hit;
      // compare in decode needs a value that already exists in EX/MEM
      assign bx_hit[gi] = id_br & (x_hit | (m_ld & m_hit));
      assign br_fwd[gi] = id_br & ~m_ld & m_hit;
   end

   assign lu_stall = |lu_hit;
   assign hold     = lu_stall | (|bx_hit);
   assign bubble   = hold;
   assign redirect = id_br & br_cond & ~hold;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
   import hzd_pkg::*;
#(
   parameter logic [OPC_W-1:0] OPC_REG    = 6'h00,
   parameter logic [OPC_W-1:0] OPC_ADDI   = 6'h08,
   parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] if_instr,
   input  logic               br_cond,
   output logic [SEL_W-1:0]   fwd_a_sel,
   output logic [SEL_W-1:0]   fwd_b_sel,
   output logic               br_fwd_a,
   output logic               br_fwd_b,
   output logic               hold,
   output logic               bubble,
   output logic               redirect
);
   logic [INSTR_W-1:0]          ifid_instr;
   uop_t                        id_u, idex_u, exmem_u, memwb_u;
   regno_t [N_SRC-1:0]          ex_src;
   logic   [N_SRC-1:0]          ex_use;
   regno_t [N_SRC-1:0]          id_src;
   logic   [N_SRC-1:0]          id_use;
   logic   [N_SRC-1:0][SEL_W-1:0] ex_sel;
   logic   [N_SRC-1:0]          br_fwd;
   logic                        lu_stall;
   logic                        unused_fields;

   hzd_decode #(
      .OPC_REG(OPC_REG), .OPC_ADDI(OPC_ADDI), .OPC_LOAD(OPC_LOAD),
      .OPC_STORE(OPC_STORE), .OPC_BRANCH(OPC_BRANCH)
   ) u_dec (
      .instr (ifid_instr),
      .uop   (id_u)
   );

   assign id_src = {id_u.rb, id_u.ra};
   assign id_use = {id_u.rb_rd, id_u.ra_rd};
   assign ex_src = {idex_u.rb, idex_u.ra};
   assign ex_use = {idex_u.rb_rd, idex_u.ra_rd};

   // stage shell: decode register freezes on hold, execute takes a bubble
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifid_instr <= '0;
         idex_u     <= '0;
         exmem_u    <= '0;
         memwb_u    <= '0;
      end else begin
         if (!hold) ifid_instr <= if_instr;
         idex_u  <= bubble ? '0 : id_u;
         exmem_u <= idex_u;
         memwb_u <= exmem_u;
      end
   end

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_op
      hzd_fwd_pick u_pick (
         .src   (ex_src[gi]),
         .used  (ex_use[gi]),
         .em_wr (exmem_u.wr),
         .em_rd (exmem_u.rd),
         .wb_wr (memwb_u.wr),
         .wb_rd (memwb_u.rd),
         .sel   (ex_sel[gi])
      );
   end

   hzd_stall_ctl u_stall (
      .id_src   (id_src),
      .id_use   (id_use),
      .id_br    (id_u.br),
      .x_wr     (idex_u.wr),
      .x_rd     (idex_u.rd),
      .x_ld     (idex_u.ld),
      .m_wr     (exmem_u.wr),
      .m_rd     (exmem_u.rd),
      .m_ld     (exmem_u.ld),
      .br_cond  (br_cond),
      .br_fwd   (br_fwd),
      .lu_stall (lu_stall),
      .hold     (hold),
      .bubble   (bubble),
      .redirect (redirect)
   );

   assign fwd_a_sel = ex_sel[0];
   assign fwd_b_sel = ex_sel[1];
   assign br_fwd_a  = br_fwd[0];
   assign br_fwd_b  = br_fwd[1];

   assign unused_fields = ^{id_u.rd, id_u.wr, id_u.ld, idex_u.br,
                            exmem_u.ra, exmem_u.rb, exmem_u.ra_rd, exmem_u.rb_rd, exmem_u.br,
                            memwb_u.ra, memwb_u.rb, memwb_u.ra_rd, memwb_u.rb_rd,
                            memwb_u.ld, memwb_u.br};
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk
   import hzd_pkg::*;
(
   input logic                      clk,
   input logic                      rst_n,
   input logic                      hold,
   input logic                      redirect,
   input logic                      lu_stall,
   input logic [SEL_W-1:0]          fwd_a_sel,
   input logic [SEL_W-1:0]          fwd_b_sel,
   input regno_t [N_SRC-1:0]        ex_src,
   input logic [INSTR_W-1:0]        ifid_instr
);
   AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11)); // R2

   AST_R0_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_src[0] == '0) |-> (fwd_a_sel == SEL_RF)); // R4

   AST_LOAD_USE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      lu_stall |=> !lu_stall); // R5

   AST_NO_REDIRECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !redirect); // R9

   AST_DECODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(ifid_instr)); // R10
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hold       (hold),
   .redirect   (redirect),
   .lu_stall   (lu_stall),
   .fwd_a_sel  (fwd_a_sel),
   .fwd_b_sel  (fwd_b_sel),
   .ex_src     (ex_src),
   .ifid_instr (ifid_instr)
);

// File: tb/sim_pipe_hazard_unit.sv
module sim_pipe_hazard_unit;
   localparam int CLK_P = 10;
   localparam int WD_CYCLES = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] if_instr = '0;
   logic        br_cond = 1'b0;
   logic [1:0]  fwd_a_sel, fwd_b_sel;
   logic        br_fwd_a, br_fwd_b, hold, bubble, redirect;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   pipe_hazard_unit u0 (
      .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .br_cond(br_cond),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
      .hold(hold), .bubble(bubble), .redirect(redirect)
   );

   always #(CLK_P/2) clk = ~clk;

   // reference pipeline: index 0 execute, 1 memory, 2 writeback
   logic [31:0] m_ifid;
   int m_wd[3];
   bit m_ld[3];
   int m_sa, m_sb;
   logic [32:0] prog[$];

   function automatic logic [31:0] rr(int s, int t, int d);
      return {6'h00, s[4:0], t[4:0], d[4:0], 11'h155};
   endfunction
   function automatic logic [31:0] ii(logic [5:0] op, int s, int t);
      return {op, s[4:0], t[4:0], 16'h0040};
   endfunction

   task automatic decode(input logic [31:0] w, output int sa, output int sb,
                         output int wd, output bit ld, output bit br);
      sa = -1; sb = -1; wd = 0; ld = 0; br = 0;
      case (w[31:26])
         6'h00: begin sa = w[25:21]; sb = w[20:16]; wd = w[15:11]; end
         6'h08: begin sa = w[25:21]; wd = w[20:16]; end
         6'h23: begin sa = w[25:21]; wd = w[20:16]; ld = 1; end
         6'h2B: begin sa = w[25:21]; sb = w[20:16]; end
         6'h04: begin sa = w[25:21]; sb = w[20:16]; br = 1; end
         default: ;
      endcase
   endtask

   function automatic int xsel(int src);
      if (src > 0 && src == m_wd[1]) return 2;
      if (src > 0 && src == m_wd[2]) return 1;
      return 0;
   endfunction

   task automatic chk(string tag, string nm, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: got %0d expected %0d", tag, nm, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ifid = '0;
      for (int k = 0; k < 3; k++) begin m_wd[k] = 0; m_ld[k] = 0; end
      m_sa = 0; m_sb = 0;
   endtask

   // one cycle: drive, compare, advance model; returns whether fetch was held
   task automatic step(input logic [32:0] ent, output bit stalled);
      int fa, fb, fw, na, nb, nw;
      bit fl, fbr, nl, nbr, lu, bh, st;
      if_instr = ent[31:0];
      br_cond  = ent[32];
      #1;
      decode(m_ifid, fa, fb, fw, fl, fbr);
      lu = m_ld[0] && m_wd[0] > 0 && ((fa > 0 && fa == m_wd[0]) || (fb > 0 && fb == m_wd[0]));
      bh = fbr && ((fa > 0 && (fa == m_wd[0] || (m_ld[1] && fa == m_wd[1]))) ||
                   (fb > 0 && (fb == m_wd[0] || (m_ld[1] && fb == m_wd[1]))));
      st = lu || bh;
      chk("R2 R3 R4 R6 R11", "fwd_a_sel", fwd_a_sel, xsel(m_sa));
      chk("R2 R3 R4 R6 R11", "fwd_b_sel", fwd_b_sel, xsel(m_sb));
      chk("R8 R4", "br_fwd_a", br_fwd_a, int'(fbr && fa > 0 && fa == m_wd[1] && !m_ld[1]));
      chk("R8 R4", "br_fwd_b", br_fwd_b, int'(fbr && fb > 0 && fb == m_wd[1] && !m_ld[1]));
      chk("R5 R7 R10", "hold", hold, int'(st));
      chk("R5 R7 R10", "bubble", bubble, int'(st));
      chk("R9", "redirect", redirect, int'(fbr && br_cond && !st));
      m_wd[2] = m_wd[1]; m_ld[2] = m_ld[1];
      m_wd[1] = m_wd[0]; m_ld[1] = m_ld[0];
      if (st) begin
         m_wd[0] = 0; m_ld[0] = 0; m_sa = -1; m_sb = -1;
      end else begin
         decode(m_ifid, na, nb, nw, nl, nbr);
         m_wd[0] = nw; m_ld[0] = nl; m_sa = na; m_sb = nb;
         m_ifid = ent[31:0];
      end
      stalled = st;
   endtask

   task automatic put(bit c, logic [31:0] w);
      prog.push_back({c, w});
   endtask
   task automatic nops(int n);
      for (int k = 0; k < n; k++) put(0, 32'hFC00_0000);
   endtask

   initial begin
      bit st;
      int pc;
      model_reset();
      repeat (2) @(negedge clk);
      #1;
      // R1: reset state
      chk("R1", "fwd_a_sel", fwd_a_sel, 0);
      chk("R1", "fwd_b_sel", fwd_b_sel, 0);
      chk("R1", "hold", hold, 0);
      chk("R1", "bubble", bubble, 0);
      chk("R1", "redirect", redirect, 0);
      chk("R1", "br_fwd", {br_fwd_a, br_fwd_b}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: bypass from memory stage, then from writeback stage
      put(0, rr(2, 3, 1)); put(0, rr(1, 4, 5)); put(0, rr(6, 1, 7)); nops(3);
      // R3: both stages write r1, younger wins
      put(0, rr(2, 3, 1)); put(0, rr(4, 5, 1)); put(0, rr(1, 1, 8)); nops(3);
      // R6: immediate and load destinations in bits 20:16, store reads both
      put(0, ii(6'h08, 2, 9)); put(0, ii(6'h2B, 9, 9)); nops(3);
      // R4: writes to r0 never bypass or interlock
      put(0, rr(2, 3, 0)); put(0, rr(0, 0, 4)); put(0, ii(6'h23, 5, 0));
      put(0, rr(0, 0, 6)); put(0, ii(6'h04, 0, 0)); nops(3);
      // R5: load-use costs one bubble, then writeback bypass
      put(0, ii(6'h23, 2, 10)); put(0, rr(3, 10, 11)); nops(3);
      put(0, ii(6'h23, 2, 12)); put(0, rr(12, 12, 13)); put(0, rr(13, 12, 14)); nops(3);
      // R7 R8: branch after ALU writer, after load, and with one gap
      put(0, rr(2, 3, 15)); put(1, ii(6'h04, 15, 0)); put(0, rr(1, 1, 1)); nops(3);
      put(0, ii(6'h23, 2, 16)); put(1, ii(6'h04, 0, 16)); put(0, rr(2, 2, 3)); nops(3);
      put(0, rr(2, 3, 17)); nops(1); put(1, ii(6'h04, 17, 17)); put(0, rr(4, 4, 4)); nops(3);
      // R9: not-taken branch, and br_cond on a non-branch
      put(0, ii(6'h04, 1, 2)); put(1, rr(1, 2, 3)); put(1, ii(6'h08, 1, 2)); nops(3);
      // R10: held decode instruction re-presented, bubble slot has no bypass
      put(0, ii(6'h23, 4, 18)); put(1, ii(6'h04, 18, 18)); put(0, rr(18, 18, 19)); nops(4);
      // R11: unknown opcodes reading r20 fields do nothing
      put(0, rr(1, 1, 20)); put(0, {6'h3F, 5'd20, 5'd20, 16'h0}); put(0, {6'h11, 5'd20, 5'd20, 16'h0}); nops(3);

      pc = 0;
      while (pc < prog.size()) begin
         step(prog[pc], st);
         if (!st) pc++;
         @(negedge clk);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: got 0 expected 1 (run completed)");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule